// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a watchdog peripheral with a free-running counter that software cannot see and a 16-bit control register. In supervision mode, the counter reaching the selected period makes the block request a soft system reset and set a sticky timeout flag. In interval mode, the same event raises a one-cycle periodic interrupt, and no reset is requested. Two clock-enable inputs stand in for a fast and a slow clock source. The control register selects which of them advances the counter.

Every write to the control register must carry a key in its upper byte. A write with the wrong key is refused and triggers an immediate reset request. The register reads back a different constant in its upper byte, so writing back a value that was just read is itself a fault. Any accepted write restarts the counter from zero, so a change of period always begins a fresh interval.

A power-on reset clears all control fields and the timeout flag. A soft reset keeps the flag, the hold bit, the clock choice and the period. It zeroes the counter and returns the block to supervision mode.

Top module: `wdt_timer`

## Requirements
- R1: A write with upper byte 0x5A is accepted. It loads hold from bit 7, interval mode from bit 4 (1 = interval), slow-clock select from bit 2 (1 = slow) and period select from bits 1:0.
- R2: A write with any other upper byte pulses resetReq high for one cycle after the write edge and leaves the control fields unchanged.
- R3: rdData always shows 0x69 in bits 15:8. The lower byte reads the fields in their write positions, with bits 6, 5 and 3 (counter clear) reading 0.
- R4: Every accepted write, with or without the clear bit (bit 3), zeroes the counter, so the next timeout comes one full period after that write.
- R5: Period select 00, 01, 10 and 11 gives 32768, 8192, 512 and 64 counts. 00 is the value after power-on reset.
- R6: The counter advances only on cycles where fastEn is high (select 0) or slowEn is high (select 1).
- R7: While hold is 1, the counter does not advance and no timeout occurs.
- R8: In supervision mode, resetReq goes high for one cycle on the edge that completes the period, and timeoutFlag is set.
- R9: In interval mode, intervalIrq pulses for one cycle at the end of every period, with no resetReq and no change to timeoutFlag.
- R10: softRst zeroes the counter and clears interval mode. It keeps hold, clock select, period select and timeoutFlag.
- R11: porRst clears every control field and timeoutFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porRst | input | 1 | Power-on reset, active high, asynchronous |
| softRst | input | 1 | Soft system reset, active high, synchronous |
| fastEn | input | 1 | Count enable from the fast clock source |
| slowEn | input | 1 | Count enable from the slow clock source |
| regWr | input | 1 | Control register write strobe |
| wrData | input | 16 | Write data, key in bits 15:8 |
| rdData | output | 16 | Control register read value |
| resetReq | output | 1 | One-cycle soft reset request |
| intervalIrq | output | 1 | One-cycle periodic interrupt |
| timeoutFlag | output | 1 | Sticky supervision timeout flag |

## Verification
A table of write words covers three cases: correct keys with varied field patterns, the read-back key, and near-miss keys. This separates key checking from field loading and shows that refused writes leave the register untouched. Each of the four periods is timed from a write: the output must stay low one count before the expected edge and rise exactly on it, which exposes off-by-one errors in the tap. Further runs cover the slow-clock source, hold, and a rewrite in mid-interval. A pass in interval mode over two periods shows the interrupt repeating and the reset staying quiet. Soft and power-on resets are then applied with non-default fields, to show which state each one keeps.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W   = 16;
  localparam int KEY_W   = 8;
  localparam logic [KEY_W-1:0] KEY_WRITE = 8'h5A;
  localparam logic [KEY_W-1:0] KEY_READ  = 8'h69;

  typedef struct packed {
    logic       hold;
    logic       interval;
    logic       slowClk;
    logic [1:0] tapSel;
  } wdtCfg_t;

  typedef struct packed {
    logic       cntClear;
    logic       cntRun;
    logic [1:0] tapSel;
  } cntCmd_t;

  function automatic int tapIndex(input logic [1:0] sel);
    case (sel)
      2'b00:   return 15;
      2'b01:   return 13;
      2'b10:   return 9;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic    clk,
  input  logic    porRst,
  input  cntCmd_t cmd,
  output logic    expire
);
  localparam int NUM_TAPS = 4;

  logic [W-1:0] count;
  logic [W-1:0] tapMask [NUM_TAPS];
  logic [W-1:0] mask;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : gMask
    assign tapMask[g] = W'((32'd1 << tapIndex(2'(g))) - 32'd1);
  end

  assign mask   = tapMask[cmd.tapSel];
  assign expire = cmd.cntRun && !cmd.cntClear && ((count & mask) == mask);

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)                       count <= '0;
    else if (cmd.cntClear || expire)  count <= '0;
    else if (cmd.cntRun)              count <= count + 1'b1;
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        porRst,
  input  logic        softRst,
  input  logic        fastEn,
  input  logic        slowEn,
  input  logic        regWr,
  input  logic [15:0] wrData,
  input  logic        expire,
  output cntCmd_t     cmd,
  output logic [15:0] rdData,
  output logic        resetReq,
  output logic        intervalIrq,
  output logic        timeoutFlag
);
  wdtCfg_t cfg;
  logic keyOk, acceptWr, badWr;

  assign keyOk    = (wrData[15:8] == KEY_WRITE);
  assign acceptWr = regWr && keyOk;
  assign badWr    = regWr && !keyOk;

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      cfg <= '0;
    end else if (softRst) begin
      cfg.interval <= 1'b0;
    end else if (acceptWr) begin
      cfg.hold     <= wrData[7];
      cfg.interval <= wrData[4];
      cfg.slowClk  <= wrData[2];
      cfg.tapSel   <= wrData[1:0];
    end
  end

  always_comb begin
    cmd.cntClear = acceptWr || softRst;
    cmd.cntRun   = !cfg.hold && (cfg.slowClk ? slowEn : fastEn);
    cmd.tapSel   = cfg.tapSel;
  end

  assign rdData = {KEY_READ, cfg.hold, 2'b00, cfg.interval, 1'b0,
                   cfg.slowClk, cfg.tapSel};

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      resetReq    <= 1'b0;
      intervalIrq <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      resetReq    <= badWr || (expire && !cfg.interval);
      intervalIrq <= expire && cfg.interval;
      if (expire && !cfg.interval) timeoutFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        porRst,
  input  logic        softRst,
  input  logic        fastEn,
  input  logic        slowEn,
  input  logic        regWr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        resetReq,
  output logic        intervalIrq,
  output logic        timeoutFlag
);
  cntCmd_t cmd;
  logic    expire;

  wdt_ctrl u_ctrl (
    .clk(clk), .porRst(porRst), .softRst(softRst), .fastEn(fastEn),
    .slowEn(slowEn), .regWr(regWr), .wrData(wrData), .expire(expire),
    .cmd(cmd), .rdData(rdData), .resetReq(resetReq),
    .intervalIrq(intervalIrq), .timeoutFlag(timeoutFlag)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .porRst(porRst), .cmd(cmd), .expire(expire)
  );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic        clk,
  input logic        porRst,
  input logic        softRst,
  input logic        fastEn,
  input logic        slowEn,
  input logic        regWr,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        resetReq,
  input logic        intervalIrq,
  input logic        timeoutFlag
);
  a_r1_accept: assert property (@(posedge clk) disable iff (porRst)
    regWr && wrData[15:8] == 8'h5A && !softRst
      |=> rdData[7:0] == ($past(wrData[7:0]) & 8'h97));

  a_r2_bad_key: assert property (@(posedge clk) disable iff (porRst)
    regWr && wrData[15:8] != 8'h5A |=> resetReq);

  a_r3_read_form: assert property (@(posedge clk) disable iff (porRst)
    rdData[15:8] == 8'h69 && rdData[6:5] == 2'b00 && !rdData[3]);

  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (porRst)
    rdData[7] && !regWr |=> !intervalIrq && !resetReq);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (porRst)
    timeoutFlag |=> timeoutFlag);

  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (porRst)
    intervalIrq |=> !intervalIrq);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (porRst)
    !(intervalIrq && resetReq));

  a_r10_soft_mode: assert property (@(posedge clk) disable iff (porRst)
    softRst |=> !rdData[4]);
endmodule

bind wdt_timer wdt_timer_chk u_chk (.*);

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
  logic        clk = 1'b0;
  logic        porRst = 1'b0;
  logic        softRst = 1'b0;
  logic        fastEn = 1'b1;
  logic        slowEn = 1'b0;
  logic        regWr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        resetReq, intervalIrq, timeoutFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int seenReq, seenIrq;

  always #5 clk = ~clk;

  wdt_timer u_dut (
    .clk(clk), .porRst(porRst), .softRst(softRst), .fastEn(fastEn),
    .slowEn(slowEn), .regWr(regWr), .wrData(wrData), .rdData(rdData),
    .resetReq(resetReq), .intervalIrq(intervalIrq), .timeoutFlag(timeoutFlag)
  );

  // {write word, expected resetReq, expected read-back}
  localparam int NVEC = 8;
  localparam logic [32:0] VEC [NVEC] = '{
    {16'h5A80, 1'b0, 16'h6980},
    {16'h6980, 1'b1, 16'h6980},
    {16'h5A93, 1'b0, 16'h6993},
    {16'hA593, 1'b1, 16'h6993},
    {16'h5A8B, 1'b0, 16'h6983},
    {16'h5B00, 1'b1, 16'h6983},
    {16'hFFFF, 1'b1, 16'h6983},
    {16'h5AE4, 1'b0, 16'h6984}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic watch(input int n);
    seenReq = 0; seenIrq = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (resetReq) seenReq++;
      if (intervalIrq) seenIrq++;
    end
  endtask

  task automatic wr(input logic [15:0] d);
    regWr = 1'b1; wrData = d;
    @(posedge clk); #1;
    regWr = 1'b0; wrData = '0;
  endtask

  task automatic doPor();
    porRst = 1'b1; step(2); porRst = 1'b0; step(1);
  endtask

  initial begin
    #1; doPor();
    check("R11 por read", rdData, 16'h6900);
    check("R11 por flag", 16'(timeoutFlag), 16'h0);
    check("R3 read key", rdData[15:8], 16'h0069);

    // key table (R1, R2, R3)
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][32:17]);
      check("R2 reset pulse", 16'(resetReq), 16'(VEC[i][16]));
      check("R1 read back", rdData, VEC[i][15:0]);
    end
    step(1);
    check("R2 pulse one cycle", 16'(resetReq), 16'h0);

    // R5 default period 32768, R8 supervision timeout
    doPor();
    wr(16'h5A00);
    step(32767);
    check("R5 32768 early", 16'(resetReq), 16'h0);
    step(1);
    check("R8 timeout reset", 16'(resetReq), 16'h1);
    check("R8 flag set", 16'(timeoutFlag), 16'h1);
    step(1);
    check("R8 single cycle", 16'(resetReq), 16'h0);

    // R10 soft reset keeps flag and fields, clears interval mode
    wr(16'h5A97);
    softRst = 1'b1; step(1); softRst = 1'b0;
    check("R10 fields kept", rdData, 16'h6987);
    check("R10 flag kept", 16'(timeoutFlag), 16'h1);
    doPor();
    check("R11 por clears fields", rdData, 16'h6900);
    check("R11 por clears flag", 16'(timeoutFlag), 16'h0);

    // R5 remaining periods
    wr(16'h5A01); step(8191);
    check("R5 8192 early", 16'(resetReq), 16'h0);
    step(1); check("R5 8192 edge", 16'(resetReq), 16'h1);
    wr(16'h5A02); step(511);
    check("R5 512 early", 16'(resetReq), 16'h0);
    step(1); check("R5 512 edge", 16'(resetReq), 16'h1);
    wr(16'h5A03); step(63);
    check("R5 64 early", 16'(resetReq), 16'h0);
    step(1); check("R5 64 edge", 16'(resetReq), 16'h1);

    // R4 clear bit reads 0 and a mid-interval write restarts the count
    wr(16'h5A0B);
    check("R4 clear reads zero", rdData, 16'h6903);
    step(40);
    wr(16'h5A0B);
    step(63); check("R4 restart early", 16'(resetReq), 16'h0);
    step(1);  check("R4 restart edge", 16'(resetReq), 16'h1);

    // R7 hold
    wr(16'h5A83);
    watch(300);
    check("R7 hold no timeout", 16'(seenReq), 16'h0);
    wr(16'h5A03); step(64);
    check("R7 release counts", 16'(resetReq), 16'h1);

    // R6 slow clock
    wr(16'h5A07);
    watch(200);
    check("R6 fast ignored", 16'(seenReq), 16'h0);
    for (int i = 0; i < 63; i++) begin
      slowEn = 1'b1; step(1); slowEn = 1'b0; step(1);
    end
    check("R6 slow early", 16'(resetReq), 16'h0);
    slowEn = 1'b1; step(1); slowEn = 1'b0;
    check("R6 slow edge", 16'(resetReq), 16'h1);

    // R9 interval mode
    doPor();
    wr(16'h5A13);
    step(63); check("R9 irq early", 16'(intervalIrq), 16'h0);
    step(1);
    check("R9 irq first", 16'(intervalIrq), 16'h1);
    check("R9 no reset", 16'(resetReq), 16'h0);
    step(1); check("R9 irq one cycle", 16'(intervalIrq), 16'h0);
    step(62); check("R9 irq gap", 16'(intervalIrq), 16'h0);
    step(1); check("R9 irq second", 16'(intervalIrq), 16'h1);
    check("R9 flag untouched", 16'(timeoutFlag), 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule